// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block turns a fast input clock into slower channel clocks. Each channel has its own divider. The high phase and the low phase of each divider are set separately as a number of input-clock cycles. A global synchronisation request stops every channel that obeys it and restarts them together. When that request is released, a channel can start from a chosen level and can wait a programmable number of cycles before its first edge. That is how several channels are aligned with a known skew between them.

Each channel can also:
- pass the input clock through unchanged (bypass);
- hold a static high level;
- balance its duty cycle automatically, using a register clocked on the falling edge to add half a cycle when the total ratio is odd;
- route one of two alternative clock sources to its output in place of the divided clock, chosen by a shared 2-bit select.

Configuration arrives as static fields. A channel copies its fields into its own shadow registers only while it is in reset or held by an obeyed synchronisation request. Changing a field while the channel runs therefore has no effect until the next reset or the next obeyed release, and the output never breaks off in the middle of a period.

Top module: `cdiv_top`

## Requirements
- R1: With duty correction off (`dcc_off`=1), the divided output stays high for H+1 and low for L+1 input cycles, where the 4-bit fields `hi_cyc`=H and `lo_cyc`=L hold each count minus one.
- R2: During reset each channel copies its configuration, and its output starts at the start level (`start_hi` 1 = high, 0 = low). That first level lasts its full count.
- R3: While `sync_req` is 1 and the channel's shadowed `nosync_en` is 0, the output is held at the start level and counting is reset. Counting restarts on the cycle after release.
- R4: Once a channel has taken `nosync_en`=1, `sync_req` has no effect on its output.
- R5: After reset or an obeyed sync release, the first transition is delayed by P input cycles (`phase_ofs`=P), so the start level lasts P plus its own count.
- R6: With `nosync_en`=1 and `force_hi`=1 the channel output is constant high. `force_hi`=1 with `nosync_en`=0 has no effect.
- R7: With `bypass_en`=1 the channel output follows the input clock `clk`, and the divider is idle.
- R8: With duty correction on (`dcc_off`=0) and an even total N=H+L+2, the high and low times are each N/2 cycles, whatever the split between H and L.
- R9: With duty correction on and an odd N, the counter gives (N-1)/2 high cycles and (N+1)/2 low cycles. A falling-edge register then stretches the high phase by half a cycle, so high and low are each N/2.
- R10: With `direct_en`=1, `route_sel`=2'b10 routes `route_a`, 2'b00 routes `route_b`, and 2'b01 or 2'b11 keeps the normal path. With `direct_en`=0 the normal path is always used.
- R11: Configuration changes made while a channel runs have no effect until the next reset or obeyed sync.
- R12: Output priority is, from highest: routed source, then forced high, then bypass, then the divided clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_req | input | 1 | Global synchronisation request, active high |
| route_a | input | 1 | Alternative source selected by route code 2'b10 |
| route_b | input | 1 | Alternative source selected by route code 2'b00 |
| route_sel | input | 2 | Shared route select code |
| lo_cyc | input | NUM_CH x 4 | Low-phase cycles minus one, per channel |
| hi_cyc | input | NUM_CH x 4 | High-phase cycles minus one, per channel |
| phase_ofs | input | NUM_CH x 4 | Delay before the first transition, per channel |
| start_hi | input | NUM_CH | Start level, per channel |
| bypass_en | input | NUM_CH | Pass the input clock through, per channel |
| nosync_en | input | NUM_CH | Ignore `sync_req`, per channel |
| force_hi | input | NUM_CH | Force the output high (needs `nosync_en`), per channel |
| dcc_off | input | NUM_CH | 1 disables duty correction, per channel |
| direct_en | input | NUM_CH | Enable routing of an alternative source, per channel |
| ch_out | output | NUM_CH | Channel clock outputs |

## Verification
The divider is exercised with:
- asymmetric splits, including the fastest one (1 high, 1 low), which show whether the high and low counts are swapped or off by one;
- balanced even and odd totals with correction on, where only a correct half-cycle stretch matches the model at both sample points of each cycle;
- phase offsets of different sizes on the two channels after a shared release, which separate the delay counter from the period counter.

Configuration changes made mid-run, and then after a sync pulse, tell a shadowing design from one that follows its inputs directly. The route, force and bypass combinations are chosen so that every pair in the priority order is tried.

// File: rtl/cdiv_pkg.sv
// Package: shared widths, shadow types and the divide-split computation.
// Assumes all count fields share the width CNT_W.
package cdiv_pkg;

    localparam int CNT_W = 4;
    localparam int TOT_W = CNT_W + 2;

    // Shared route select codes
    typedef enum logic [1:0] {
        RSEL_B   = 2'b00,
        RSEL_DIV = 2'b01,
        RSEL_A   = 2'b10,
        RSEL_RSV = 2'b11
    } rsel_e;

    // Control bits shadowed per channel
    typedef struct packed {
        logic       bypass;
        logic       nosync;
        logic       force_hi;
        logic       direct;
        logic [1:0] rsel;
    } shd_ctl_t;

    // Phase limits (count minus one) and half-cycle stretch flag
    typedef struct packed {
        logic [CNT_W-1:0] lim_hi;
        logic [CNT_W-1:0] lim_lo;
        logic             stretch;
    } split_t;

    // Derive the high and low limits from the fields and the correction option
    function automatic split_t calc_split(input logic [CNT_W-1:0] lo,
                                          input logic [CNT_W-1:0] hi,
                                          input logic             dcc_off);
        split_t           s;
        logic [TOT_W-1:0] n;
        logic [TOT_W-1:0] h;
        n = {2'b00, lo} + {2'b00, hi} + TOT_W'(2);
        h = n >> 1;
        if (dcc_off) begin
            s.lim_hi  = hi;
            s.lim_lo  = lo;
            s.stretch = 1'b0;
        end else begin
            s.lim_hi  = CNT_W'(h - TOT_W'(1));
            s.lim_lo  = CNT_W'(n - h - TOT_W'(1));
            s.stretch = n[0];
        end
        return s;
    endfunction

endpackage

// File: rtl/cdiv_counter.sv
// Module: cdiv_counter
// Level generator on the rising edge. Loads the start level and the phase
// delay while held, counts the delay down, then alternates the high and low
// phases using the shadowed limits. Assumes the limits are stable while it runs.
module cdiv_counter
    import cdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             idle,
    input  logic             start_in,
    input  logic [CNT_W-1:0] phase_in,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [CNT_W-1:0] lim_lo,
    output logic             lvl
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dly_q;
    logic             lvl_q;
    logic [CNT_W-1:0] cur_lim;

    // Limit of the phase currently being output
    assign cur_lim = lvl_q ? lim_hi : lim_lo;

    // Delay, phase counting and level toggling
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            lvl_q <= start_in;
            cnt_q <= '0;
            dly_q <= phase_in;
        end else if (!idle) begin
            if (dly_q != '0) begin
                dly_q <= dly_q - 1'b1;
            end else if (cnt_q == cur_lim) begin
                lvl_q <= ~lvl_q;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lvl = lvl_q;

    // R1: the count never passes the limit of the current phase
    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cur_lim);

    // R3: a hold cycle leaves the output at the start level
    p_hold_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (lvl_q == $past(start_in)));

    // R5: no transition while the phase delay is pending
    p_delay_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && dly_q != '0) |=> $stable(lvl_q));

endmodule

// File: rtl/cdiv_dcc.sv
// Module: cdiv_dcc
// Duty-cycle helper. Samples the level on the falling edge and ORs it in
// when stretching is enabled, extending each high phase by half a cycle.
// Assumes the level only changes on rising edges.
module cdiv_dcc (
    input  logic clk,
    input  logic rst_n,
    input  logic stretch,
    input  logic lvl,
    output logic out
);

    logic neg_q;

    // Falling-edge copy of the level
    always_ff @(negedge clk) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= lvl;
    end

    // Stretch the high phase only when asked
    assign out = stretch ? (lvl | neg_q) : lvl;

endmodule

// File: rtl/cdiv_outmux.sv
// Module: cdiv_outmux
// Output selection for one channel. Priority from highest: routed source,
// forced high, bypass clock, divided clock. Assumes shadowed controls.
module cdiv_outmux
    import cdiv_pkg::*;
(
    input  logic     clk_in,
    input  logic     route_a,
    input  logic     route_b,
    input  shd_ctl_t ctl,
    input  logic     div_out,
    output logic     out
);

    // Priority selection of the channel output
    always_comb begin
        if (ctl.direct && ctl.rsel == RSEL_A)      out = route_a;
        else if (ctl.direct && ctl.rsel == RSEL_B) out = route_b;
        else if (ctl.nosync && ctl.force_hi)       out = 1'b1;
        else if (ctl.bypass)                       out = clk_in;
        else                                       out = div_out;
    end

endmodule

// File: rtl/cdiv_channel.sv
// Module: cdiv_channel
// One divider channel. Shadows its configuration while it is in reset or
// held by an obeyed sync, so changes made while it runs are ignored.
// Assumes sync_req is synchronous to clk.
module cdiv_channel
    import cdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_req,
    input  logic             route_a,
    input  logic             route_b,
    input  logic [1:0]       route_sel,
    input  logic [CNT_W-1:0] lo_cyc,
    input  logic [CNT_W-1:0] hi_cyc,
    input  logic [CNT_W-1:0] phase_ofs,
    input  logic             start_hi,
    input  logic             bypass_en,
    input  logic             nosync_en,
    input  logic             force_hi,
    input  logic             dcc_off,
    input  logic             direct_en,
    output logic             ch_out
);

    shd_ctl_t ctl_q;
    split_t   split_q;
    logic     hold;
    logic     lvl;
    logic     dcc_out;

    // Obeyed sync holds the channel
    assign hold = sync_req && !ctl_q.nosync;

    // Shadow load during reset or hold
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            ctl_q.bypass   <= bypass_en;
            ctl_q.nosync   <= nosync_en;
            ctl_q.force_hi <= force_hi;
            ctl_q.direct   <= direct_en;
            ctl_q.rsel     <= route_sel;
            split_q        <= calc_split(lo_cyc, hi_cyc, dcc_off);
        end
    end

    cdiv_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .idle     (ctl_q.bypass),
        .start_in (start_hi),
        .phase_in (phase_ofs),
        .lim_hi   (split_q.lim_hi),
        .lim_lo   (split_q.lim_lo),
        .lvl      (lvl)
    );

    cdiv_dcc u_dcc (
        .clk     (clk),
        .rst_n   (rst_n),
        .stretch (split_q.stretch),
        .lvl     (lvl),
        .out     (dcc_out)
    );

    cdiv_outmux u_mux (
        .clk_in  (clk),
        .route_a (route_a),
        .route_b (route_b),
        .ctl     (ctl_q),
        .div_out (dcc_out),
        .out     (ch_out)
    );

    // R11: the shadow is frozen while the channel runs
    p_shadow_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> ($stable(ctl_q) && $stable(split_q)));

endmodule

// File: rtl/cdiv_top.sv
// Module: cdiv_top
// Top of the divider block: NUM_CH independent channels that share the
// input clock, the sync request and the route select.
module cdiv_top
    import cdiv_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sync_req,
    input  logic                          route_a,
    input  logic                          route_b,
    input  logic [1:0]                    route_sel,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  lo_cyc,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  hi_cyc,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  phase_ofs,
    input  logic [NUM_CH-1:0]             start_hi,
    input  logic [NUM_CH-1:0]             bypass_en,
    input  logic [NUM_CH-1:0]             nosync_en,
    input  logic [NUM_CH-1:0]             force_hi,
    input  logic [NUM_CH-1:0]             dcc_off,
    input  logic [NUM_CH-1:0]             direct_en,
    output logic [NUM_CH-1:0]             ch_out
);

    // One channel per index
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cdiv_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_req  (sync_req),
            .route_a   (route_a),
            .route_b   (route_b),
            .route_sel (route_sel),
            .lo_cyc    (lo_cyc[g]),
            .hi_cyc    (hi_cyc[g]),
            .phase_ofs (phase_ofs[g]),
            .start_hi  (start_hi[g]),
            .bypass_en (bypass_en[g]),
            .nosync_en (nosync_en[g]),
            .force_hi  (force_hi[g]),
            .dcc_off   (dcc_off[g]),
            .direct_en (direct_en[g]),
            .ch_out    (ch_out[g])
        );
    end

endmodule

// File: tb/sim_cdiv_top.sv
// Bench: behavioural model of the divider, compared at a point in the high
// half and a point in the low half of every input clock cycle.
module sim_cdiv_top;
    import cdiv_pkg::*;

    localparam int CLK_PERIOD = 20;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_req = 1'b0;
    logic route_a = 1'b0;
    logic route_b = 1'b0;
    logic [1:0] route_sel = 2'b01;
    logic [NCH-1:0][CNT_W-1:0] lo_cyc = '0, hi_cyc = '0, phase_ofs = '0;
    logic [NCH-1:0] start_hi = '0, bypass_en = '0, nosync_en = '0;
    logic [NCH-1:0] force_hi = '0, dcc_off = '1, direct_en = '0;
    logic [NCH-1:0] ch_out;

    int n_chk = 0;
    int n_fail = 0;
    string tag [NCH];

    // model state
    int m_k [NCH];
    int m_ph [NCH], m_dhi [NCH], m_dlo [NCH];
    bit m_start [NCH], m_str [NCH], m_byp [NCH], m_nos [NCH];
    bit m_frc [NCH], m_dir [NCH];
    int m_sel [NCH];
    bit m_lvl [NCH], m_neg [NCH];

    cdiv_top #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .route_a(route_a),
        .route_b(route_b), .route_sel(route_sel), .lo_cyc(lo_cyc),
        .hi_cyc(hi_cyc), .phase_ofs(phase_ofs), .start_hi(start_hi),
        .bypass_en(bypass_en), .nosync_en(nosync_en), .force_hi(force_hi),
        .dcc_off(dcc_off), .direct_en(direct_en), .ch_out(ch_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // level after k running cycles, from the period timeline
    function automatic bit level_at(int ch);
        int m, d0, d1;
        if (m_k[ch] <= m_ph[ch]) return m_start[ch];
        m  = m_k[ch] - m_ph[ch];
        d0 = m_start[ch] ? m_dhi[ch] : m_dlo[ch];
        d1 = m_start[ch] ? m_dlo[ch] : m_dhi[ch];
        return ((m % (d0 + d1)) < d0) ? m_start[ch] : !m_start[ch];
    endfunction

    task automatic model_rise();
        for (int ch = 0; ch < NCH; ch++) begin
            if (!rst_n || (sync_req && !m_nos[ch])) begin
                int n;
                n = int'(lo_cyc[ch]) + int'(hi_cyc[ch]) + 2;
                m_ph[ch] = int'(phase_ofs[ch]);
                m_start[ch] = start_hi[ch];
                m_byp[ch] = bypass_en[ch];
                m_nos[ch] = nosync_en[ch];
                m_frc[ch] = force_hi[ch];
                m_dir[ch] = direct_en[ch];
                m_sel[ch] = int'(route_sel);
                if (dcc_off[ch]) begin
                    m_dhi[ch] = int'(hi_cyc[ch]) + 1;
                    m_dlo[ch] = int'(lo_cyc[ch]) + 1;
                    m_str[ch] = 1'b0;
                end else begin
                    m_dhi[ch] = n / 2;
                    m_dlo[ch] = n - n / 2;
                    m_str[ch] = (n % 2) == 1;
                end
                m_k[ch] = 0;
            end else if (!m_byp[ch]) begin
                m_k[ch]++;
            end
            m_lvl[ch] = level_at(ch);
        end
    endtask

    function automatic bit expect_out(int ch, bit clk_hi);
        if (m_dir[ch] && m_sel[ch] == 2) return route_a;
        if (m_dir[ch] && m_sel[ch] == 0) return route_b;
        if (m_nos[ch] && m_frc[ch]) return 1'b1;
        if (m_byp[ch]) return clk_hi;
        return m_str[ch] ? (m_lvl[ch] | m_neg[ch]) : m_lvl[ch];
    endfunction

    task automatic compare(bit clk_hi);
        for (int ch = 0; ch < NCH; ch++) begin
            bit e;
            e = expect_out(ch, clk_hi);
            n_chk++;
            if (ch_out[ch] !== e) begin
                n_fail++;
                $display("FAIL %s ch%0d t=%0t actual=%b expected=%b",
                         tag[ch], ch, $time, ch_out[ch], e);
            end
        end
    endtask

    // one clock cycle: model both edges, compare in each half
    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_rise();
            #(CLK_PERIOD/4);
            compare(1'b1);
            @(negedge clk);
            for (int ch = 0; ch < NCH; ch++) m_neg[ch] = rst_n ? m_lvl[ch] : 1'b0;
            #(CLK_PERIOD/4);
            compare(1'b0);
        end
    endtask

    task automatic set_ch(int ch, int lo, int hi, int ph, bit st, bit doff,
                          bit byp, bit nos, bit frc, bit dir);
        lo_cyc[ch] = CNT_W'(lo);
        hi_cyc[ch] = CNT_W'(hi);
        phase_ofs[ch] = CNT_W'(ph);
        start_hi[ch] = st;
        dcc_off[ch] = doff;
        bypass_en[ch] = byp;
        nosync_en[ch] = nos;
        force_hi[ch] = frc;
        direct_en[ch] = dir;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R2 reset state, then R1 asymmetric and fastest ratios
        tag[0] = "R2"; tag[1] = "R2";
        set_ch(0, 1, 2, 0, 0, 1, 0, 0, 0, 0);
        set_ch(1, 0, 0, 0, 1, 1, 0, 0, 0, 0);
        cyc(2);
        do_reset();
        cyc(6);
        tag[0] = "R1"; tag[1] = "R1";
        cyc(30);

        // R3 hold under sync, R5 phase offsets after release
        set_ch(0, 1, 2, 3, 1, 1, 0, 0, 0, 0);
        set_ch(1, 2, 0, 5, 0, 1, 0, 0, 0, 0);
        tag[0] = "R3"; tag[1] = "R3";
        sync_req = 1'b1; cyc(4); sync_req = 1'b0;
        tag[0] = "R5"; tag[1] = "R5";
        cyc(30);

        // R11 mid-run changes ignored, then applied by a sync pulse
        set_ch(0, 1, 5, 0, 0, 1, 1, 0, 0, 0);
        set_ch(1, 3, 1, 2, 1, 1, 0, 0, 0, 0);
        tag[0] = "R11"; tag[1] = "R11";
        cyc(25);
        sync_req = 1'b1; cyc(1); sync_req = 1'b0;
        set_ch(0, 1, 2, 0, 0, 1, 0, 0, 0, 0);
        cyc(25);

        // R4 nosync taken at the hold, then sync ignored
        set_ch(1, 2, 1, 0, 0, 1, 0, 1, 0, 0);
        tag[0] = "R3"; tag[1] = "R4";
        sync_req = 1'b1; cyc(12); sync_req = 1'b0;
        cyc(10);

        // R6 force with and without nosync
        set_ch(0, 1, 1, 0, 0, 1, 0, 0, 1, 0);
        set_ch(1, 1, 1, 0, 0, 1, 0, 1, 1, 0);
        tag[0] = "R6"; tag[1] = "R6";
        do_reset();
        cyc(10);
        sync_req = 1'b1; cyc(3); sync_req = 1'b0;
        cyc(10);

        // R7 bypass, R8 balanced even ratio
        set_ch(0, 2, 2, 0, 0, 1, 1, 0, 0, 0);
        set_ch(1, 1, 3, 0, 0, 0, 0, 0, 0, 0);
        tag[0] = "R7"; tag[1] = "R8";
        do_reset();
        cyc(24);

        // R9 odd ratios with half-cycle stretch
        set_ch(0, 1, 2, 1, 1, 0, 0, 0, 0, 0);
        set_ch(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        tag[0] = "R9"; tag[1] = "R9";
        do_reset();
        cyc(30);

        // R10 and R12 routing: select A, select B, then normal path codes
        set_ch(0, 1, 1, 0, 0, 1, 1, 0, 0, 1);
        set_ch(1, 1, 1, 0, 0, 1, 1, 1, 1, 1);
        tag[0] = "R12"; tag[1] = "R12";
        route_sel = 2'b10;
        do_reset();
        for (int i = 0; i < 10; i++) begin route_a = ~route_a; cyc(1); end
        route_sel = 2'b00;
        tag[0] = "R10"; tag[1] = "R10";
        do_reset();
        for (int i = 0; i < 10; i++) begin route_b = ~route_b; route_a = ~route_a; cyc(1); end
        route_sel = 2'b01;
        tag[0] = "R12"; tag[1] = "R12";
        do_reset();
        cyc(8);
        route_sel = 2'b11;
        set_ch(0, 0, 2, 0, 1, 1, 0, 0, 0, 1);
        tag[0] = "R10";
        do_reset();
        for (int i = 0; i < 12; i++) begin route_a = ~route_a; cyc(1); end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule